// File: doc/BRIEF.md
# Tape Transport Mode Controller

This block is the mode sequencer for a tape transport. It watches a set of panel buttons (stop, pause, forward, rewind, play and record) and a synchronous reset, and drives exactly one of six tape drive lines: stopped, paused, fast forward, rewind, play or record. The drive lines are a pure function of the current state (a Moore machine).

Every motion mode is entered through a one-cycle preparation state. During that cycle the tape is still held stopped, and on the following clock edge the motion drive comes on. Recording starts only when record and play are pressed together. While playing, a press of pause freezes the tape, and a second press resumes play. A button that is held down is acted on once.

Buttons are expected to be clean, synchronous levels. Debouncing, motor timing and end-of-tape sensing belong to the surrounding logic.

Top module: `tape_transport_ctrl`

## Requirements
- R1: When `rst` is high at a clock edge, the controller is in the stopped mode after that edge, whatever the buttons are doing. Only `tapeStop` is high in that mode.
- R2: When `btnStop` is high at a clock edge and `rst` is low, the controller is in the stopped mode after that edge. This holds from every state, including the preparation states, and overrides every other button.
- R3: In the stopped mode, `btnFwd` gives one cycle with `tapeStop` high and then `tapeFwd` high from the next edge on.
- R4: In the stopped mode, `btnRew` gives one cycle with `tapeStop` high and then `tapeRew` high.
- R5: In the stopped mode, `btnPlay` alone gives one cycle with `tapeStop` high and then `tapePlay` high.
- R6: Recording is entered only when `btnRec` and `btnPlay` are high together. It takes one cycle with `tapeStop` high and then `tapeRec` high. `btnRec` on its own leaves the controller stopped.
- R7: In the stopped mode, buttons pressed together are resolved in this order: record+play first, then forward, then rewind, then play alone.
- R8: In play, a rising edge on `btnPause` (high now, low at the previous edge) moves to pause, with `tapePause` high. In pause, a rising edge moves back to play. A held `btnPause` toggles only once.
- R9: The forward, rewind, play and record buttons have no effect in forward, rewind, play, record or pause. A pause edge has no effect outside play and pause.
- R10: Exactly one of the six drive outputs is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| btnStop | input | 1 | Stop button |
| btnPause | input | 1 | Pause button (edge-acted) |
| btnFwd | input | 1 | Fast-forward button |
| btnRew | input | 1 | Rewind button |
| btnPlay | input | 1 | Play button |
| btnRec | input | 1 | Record button (needs play as well) |
| tapeStop | output | 1 | Tape held stopped |
| tapePause | output | 1 | Tape paused |
| tapeFwd | output | 1 | Fast-forward drive |
| tapeRew | output | 1 | Rewind drive |
| tapePlay | output | 1 | Play drive |
| tapeRec | output | 1 | Record drive |

## Verification
The embedded assertions check several properties on every cycle:
- reset and stop always return the controller to the stopped mode;
- a preparation state always advances to its motion state;
- record is never prepared without play;
- play holds unless a pause edge arrives;
- the drive lines stay one-hot.

Some behaviour can only be shown by the bench's scripted sequences. These include the resolution order among simultaneous buttons in the stopped mode, and the fact that each mode's buttons are ignored across all button combinations in the other modes. They also include single toggling under a held pause button, and the exact one-cycle stopped delay before each motion starts.

// File: rtl/tape_mode_pkg.sv
package tape_mode_pkg;

  typedef enum logic [3:0] {
    ST_STOP      = 4'd0,
    ST_PREP_FWD  = 4'd1,
    ST_FWD       = 4'd2,
    ST_PREP_REW  = 4'd3,
    ST_REW       = 4'd4,
    ST_PREP_PLAY = 4'd5,
    ST_PLAY      = 4'd6,
    ST_PAUSE     = 4'd7,
    ST_PREP_REC  = 4'd8,
    ST_REC       = 4'd9
  } modeState_t;

  // Conditioned button requests, front end to sequencer
  typedef struct packed {
    logic rst;
    logic stop;
    logic pauseRise;
    logic fwd;
    logic rew;
    logic play;
    logic recPlay;
  } btnReq_t;

  // Drive strobes, sequencer to output stage
  typedef struct packed {
    logic stopDrv;
    logic pauseDrv;
    logic fwdDrv;
    logic rewDrv;
    logic playDrv;
    logic recDrv;
  } driveStb_t;

  localparam int DRIVE_W = $bits(driveStb_t);

endpackage

// File: rtl/tape_btn_front.sv
module tape_btn_front
  import tape_mode_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    btnStop,
  input  logic    btnPause,
  input  logic    btnFwd,
  input  logic    btnRew,
  input  logic    btnPlay,
  input  logic    btnRec,
  output btnReq_t req
);

  // Previous pause level, tracked through reset so a press held across
  // reset is not seen as a new edge.
  logic pausePrev;

  always_ff @(posedge clk) begin
    pausePrev <= btnPause;
  end

  always_comb begin
    req.rst       = rst;
    req.stop      = btnStop;
    req.pauseRise = btnPause & ~pausePrev;
    req.fwd       = btnFwd;
    req.rew       = btnRew;
    req.play      = btnPlay;
    req.recPlay   = btnRec & btnPlay;
  end

endmodule

// File: rtl/tape_mode_fsm.sv
module tape_mode_fsm
  import tape_mode_pkg::*;
(
  input  logic      clk,
  input  btnReq_t   req,
  output driveStb_t stb
);

  modeState_t cur;
  modeState_t nxt;

  always_comb begin
    nxt = cur;
    case (cur)
      ST_STOP: begin
        if (req.recPlay)   nxt = ST_PREP_REC;
        else if (req.fwd)  nxt = ST_PREP_FWD;
        else if (req.rew)  nxt = ST_PREP_REW;
        else if (req.play) nxt = ST_PREP_PLAY;
      end
      ST_PREP_FWD:  nxt = ST_FWD;
      ST_PREP_REW:  nxt = ST_REW;
      ST_PREP_PLAY: nxt = ST_PLAY;
      ST_PREP_REC:  nxt = ST_REC;
      ST_PLAY:      if (req.pauseRise) nxt = ST_PAUSE;
      ST_PAUSE:     if (req.pauseRise) nxt = ST_PLAY;
      ST_FWD, ST_REW, ST_REC: nxt = cur;
      default:      nxt = ST_STOP;
    endcase
    if (req.stop) nxt = ST_STOP;
    if (req.rst)  nxt = ST_STOP;
  end

  always_ff @(posedge clk) begin
    cur <= nxt;
  end

  always_comb begin
    stb = '0;
    case (cur)
      ST_PAUSE: stb.pauseDrv = 1'b1;
      ST_FWD:   stb.fwdDrv   = 1'b1;
      ST_REW:   stb.rewDrv   = 1'b1;
      ST_PLAY:  stb.playDrv  = 1'b1;
      ST_REC:   stb.recDrv   = 1'b1;
      default:  stb.stopDrv  = 1'b1;
    endcase
  end

  AST_RESET_TO_STOP: assert property (@(posedge clk)
    req.rst |=> cur == ST_STOP); // R1

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (req.rst)
    req.stop |=> cur == ST_STOP); // R2

  AST_PREP_FWD_ADVANCES: assert property (@(posedge clk) disable iff (req.rst)
    (cur == ST_PREP_FWD && !req.stop) |=> cur == ST_FWD); // R3

  AST_PREP_REW_ADVANCES: assert property (@(posedge clk) disable iff (req.rst)
    (cur == ST_PREP_REW && !req.stop) |=> cur == ST_REW); // R4

  AST_PREP_PLAY_ADVANCES: assert property (@(posedge clk) disable iff (req.rst)
    (cur == ST_PREP_PLAY && !req.stop) |=> cur == ST_PLAY); // R5

  AST_REC_NEEDS_PLAY: assert property (@(posedge clk) disable iff (req.rst)
    (cur == ST_STOP && !req.recPlay) |=> cur != ST_PREP_REC); // R6

  AST_PLAY_HOLDS: assert property (@(posedge clk) disable iff (req.rst)
    (cur == ST_PLAY && !req.stop && !req.pauseRise) |=> cur == ST_PLAY); // R8

  AST_FWD_HOLDS: assert property (@(posedge clk) disable iff (req.rst)
    (cur == ST_FWD && !req.stop) |=> cur == ST_FWD); // R9

endmodule

// File: rtl/tape_drive_out.sv
module tape_drive_out
  import tape_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  driveStb_t stb,
  output logic      tapeStop,
  output logic      tapePause,
  output logic      tapeFwd,
  output logic      tapeRew,
  output logic      tapePlay,
  output logic      tapeRec
);

  logic [DRIVE_W-1:0] driveVec;

  assign tapeStop  = stb.stopDrv;
  assign tapePause = stb.pauseDrv;
  assign tapeFwd   = stb.fwdDrv;
  assign tapeRew   = stb.rewDrv;
  assign tapePlay  = stb.playDrv;
  assign tapeRec   = stb.recDrv;
  assign driveVec  = {tapeStop, tapePause, tapeFwd, tapeRew, tapePlay, tapeRec};

  AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    $countones(driveVec) == 1); // R10

  AST_STOP_AFTER_RESET: assert property (@(posedge clk)
    rst |=> tapeStop); // R1

endmodule

// File: rtl/tape_transport_ctrl.sv
module tape_transport_ctrl
  import tape_mode_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic btnStop,
  input  logic btnPause,
  input  logic btnFwd,
  input  logic btnRew,
  input  logic btnPlay,
  input  logic btnRec,
  output logic tapeStop,
  output logic tapePause,
  output logic tapeFwd,
  output logic tapeRew,
  output logic tapePlay,
  output logic tapeRec
);

  btnReq_t   req;
  driveStb_t stb;

  tape_btn_front u_front (
    .clk      (clk),
    .rst      (rst),
    .btnStop  (btnStop),
    .btnPause (btnPause),
    .btnFwd   (btnFwd),
    .btnRew   (btnRew),
    .btnPlay  (btnPlay),
    .btnRec   (btnRec),
    .req      (req)
  );

  tape_mode_fsm u_fsm (
    .clk (clk),
    .req (req),
    .stb (stb)
  );

  tape_drive_out u_out (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .tapeStop  (tapeStop),
    .tapePause (tapePause),
    .tapeFwd   (tapeFwd),
    .tapeRew   (tapeRew),
    .tapePlay  (tapePlay),
    .tapeRec   (tapeRec)
  );

endmodule

// File: tb/tape_transport_ctrl_tb.sv
module tape_transport_ctrl_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bStop = 1'b0, bPause = 1'b0, bFwd = 1'b0, bRew = 1'b0, bPlay = 1'b0, bRec = 1'b0;
  logic tStop, tPause, tFwd, tRew, tPlay, tRec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Button vector order {stop, pause, fwd, rew, play, rec}
  localparam logic [5:0] B_STOP  = 6'b100000;
  localparam logic [5:0] B_PAUSE = 6'b010000;
  localparam logic [5:0] B_FWD   = 6'b001000;
  localparam logic [5:0] B_REW   = 6'b000100;
  localparam logic [5:0] B_PLAY  = 6'b000010;
  localparam logic [5:0] B_REC   = 6'b000001;
  // Output vector order {stop, pause, fwd, rew, play, rec}
  localparam logic [5:0] O_STOP  = 6'b100000;
  localparam logic [5:0] O_PAUSE = 6'b010000;
  localparam logic [5:0] O_FWD   = 6'b001000;
  localparam logic [5:0] O_REW   = 6'b000100;
  localparam logic [5:0] O_PLAY  = 6'b000010;
  localparam logic [5:0] O_REC   = 6'b000001;

  always #4 clk = ~clk;

  tape_transport_ctrl u_dut (
    .clk(clk), .rst(rst),
    .btnStop(bStop), .btnPause(bPause), .btnFwd(bFwd), .btnRew(bRew),
    .btnPlay(bPlay), .btnRec(bRec),
    .tapeStop(tStop), .tapePause(tPause), .tapeFwd(tFwd), .tapeRew(tRew),
    .tapePlay(tPlay), .tapeRec(tRec)
  );

  wire [5:0] outs = {tStop, tPause, tFwd, tRew, tPlay, tRec};

  task automatic setBtn(input logic [5:0] b);
    {bStop, bPause, bFwd, bRew, bPlay, bRec} = b;
  endtask

  // One clock; sample 1 ns after the edge, R10 one-hot checked each cycle
  task automatic step();
    @(posedge clk);
    #1;
    checks++;
    if ($countones(outs) != 1) begin
      fails++;
      $display("FAIL R10 one-hot actual=%b expected=one bit set", outs);
    end
  endtask

  task automatic expectOut(input logic [5:0] exp, input string tag);
    checks++;
    if (outs !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, outs, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    setBtn(6'b0);
    step();
    rst = 1'b0;
    step();
  endtask

  task automatic enter(input logic [5:0] b);
    doReset();
    setBtn(b);
    step();
    setBtn(6'b0);
    step();
  endtask

  // Motion reached from the stopped mode (R2, R7 order)
  function automatic logic [5:0] fromStop(input logic [5:0] b);
    if (b[5])         return O_STOP;
    if (b[1] && b[0]) return O_REC;
    if (b[3])         return O_FWD;
    if (b[2])         return O_REW;
    if (b[1])         return O_PLAY;
    return O_STOP;
  endfunction

  function automatic string tagOf(input logic [5:0] o);
    case (o)
      O_FWD:   return "R3/R7 forward";
      O_REW:   return "R4/R7 rewind";
      O_PLAY:  return "R5/R7 play";
      O_REC:   return "R6/R7 record";
      default: return "R2/R6 stay stopped";
    endcase
  endfunction

  initial begin
    #1600000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] modes [4];
    logic [5:0] exps  [4];
    modes[0] = B_FWD;          exps[0] = O_FWD;
    modes[1] = B_REW;          exps[1] = O_REW;
    modes[2] = B_PLAY;         exps[2] = O_PLAY;
    modes[3] = B_REC | B_PLAY; exps[3] = O_REC;

    // R1: reset state
    setBtn(6'b0);
    step();
    expectOut(O_STOP, "R1 reset state");

    // Every button combination from the stopped mode
    for (int b = 0; b < 64; b++) begin
      doReset();
      setBtn(6'(b));
      step();
      expectOut(O_STOP, "R3/R4/R5/R6 preparation cycle stays stopped");
      setBtn(6'b0);
      step();
      expectOut(fromStop(6'(b)), tagOf(fromStop(6'(b))));
    end

    // R9 / R8: buttons inside each motion mode (stop released)
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 32; b++) begin
        logic [5:0] e;
        enter(modes[m]);
        expectOut(exps[m], "R9 mode reached");
        e = (exps[m] == O_PLAY && b[4]) ? O_PAUSE : exps[m];
        setBtn(6'(b));
        step();
        expectOut(e, (e == O_PAUSE) ? "R8 pause from play" : "R9 button ignored");
        step();
        expectOut(e, "R8 held button no retoggle");
      end
    end

    // Pause mode sweep
    for (int b = 0; b < 32; b++) begin
      enter(B_PLAY);
      setBtn(B_PAUSE);
      step();
      setBtn(6'b0);
      step();
      expectOut(O_PAUSE, "R8 in pause");
      setBtn(6'(b));
      step();
      expectOut(b[4] ? O_PLAY : O_PAUSE, b[4] ? "R8 resume play" : "R9 ignored in pause");
    end

    // R8: held pause toggles once
    enter(B_PLAY);
    setBtn(B_PAUSE);
    step();
    expectOut(O_PAUSE, "R8 first press");
    step();
    step();
    expectOut(O_PAUSE, "R8 held no toggle");
    setBtn(6'b0);
    step();
    expectOut(O_PAUSE, "R8 released");
    setBtn(B_PAUSE);
    step();
    expectOut(O_PLAY, "R8 second press");

    // R2: stop from each motion mode and from pause
    for (int m = 0; m < 4; m++) begin
      enter(modes[m]);
      setBtn(B_STOP | B_FWD | B_PLAY);
      step();
      expectOut(O_STOP, "R2 stop from motion");
      setBtn(6'b0);
      step();
      expectOut(O_STOP, "R2 remains stopped");
    end
    enter(B_PLAY);
    setBtn(B_PAUSE);
    step();
    setBtn(B_STOP);
    step();
    expectOut(O_STOP, "R2 stop from pause");

    // R2: stop during preparation cancels the motion
    for (int m = 0; m < 4; m++) begin
      doReset();
      setBtn(modes[m]);
      step();
      setBtn(B_STOP);
      step();
      expectOut(O_STOP, "R2 stop in preparation");
      setBtn(6'b0);
      step();
      expectOut(O_STOP, "R2 motion cancelled");
    end

    // R1: reset beats every button, from each mode
    for (int m = 0; m < 4; m++) begin
      enter(modes[m]);
      rst = 1'b1;
      setBtn(6'h3f);
      step();
      expectOut(O_STOP, "R1 reset priority");
      rst = 1'b0;
      setBtn(6'b0);
      step();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule